// File: doc/BRIEF.md
# Serial-Loaded Octal DAC Register Controller

This block is the digital front end of an eight-channel, 10-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial port made of a serial clock, a data line and an active-low select/load strobe. While the strobe is low, each rising serial-clock edge shifts one bit into a 16-bit shift register. When the strobe rises, the register is decoded. Its leading 4-bit field chooses one channel, all channels, a sleep command or no change. The 10-bit field that follows is the code to write. The two trailing bits are ignored.

All three serial lines pass through two-flop synchronizers into the system clock domain, and their edges are detected there. The only asynchronous path is the active-low clear. The last stage of the shift register drives a serial data output, so several controllers can be chained on a shared clock and load line. Sleep marks every channel output as high-impedance and keeps every stored code. Any later load that is not a sleep command ends sleep.

Top module: `octal_dac_ctrl`

## Requirements
- R1: A word is the last 16 bits shifted before the load strobe rises, received MSB first: bits [15:12] are the address, bits [11:2] are the code, and bits [1:0] are ignored. Any earlier bits have no effect.
- R2: Shifting happens only on a rising edge of `ser_clk` while `ser_load_n` is low. Clock edges while `ser_load_n` is high leave the shift register unchanged.
- R3: On a rising edge of `ser_load_n`, address N (1 to 8) writes the code to channel N-1, held in `ch_code[(N-1)*10 +: 10]`. The other channels are unchanged.
- R4: Address 4'b1111 writes the same code to all eight channels.
- R5: Addresses 4'b0000 and 4'b1001 through 4'b1101 change no channel.
- R6: Address 4'b1110 sets `sleep` and drives all eight `ch_hiz` bits to 1. The code in that word is ignored, and all channels keep their values.
- R7: A load to any address other than 4'b1110, including the no-change addresses, clears `sleep` and `ch_hiz`. Channels that load does not write keep their values from before the sleep.
- R8: `ser_dout` shows the bit that was shifted in 16 shifts earlier. A stored word therefore leaves on `ser_dout` MSB first as the next word shifts in.
- R9: While `clr_n` is low, the shift register, all channel codes and `sleep` are zero. This takes effect without waiting for a clock edge.
- R10: A high `rst` on a rising `clk` edge sets all channel codes, the shift register, `sleep` and `ch_hiz` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| clr_n | input | 1 | Asynchronous active-low clear |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_load_n | input | 1 | Select when low; the rising edge loads |
| ser_dout | output | 1 | Serial data out, for chaining |
| ch_code | output | 80 | Eight 10-bit channel codes; channel 0 is in the low bits |
| ch_hiz | output | 8 | Per-channel high-impedance indicators |
| sleep | output | 1 | Sleep status |

## Verification
The case that is hardest to reach from the ports is proving that serial-clock edges are ignored while the strobe is high. The shift register has no direct view. To reach it, the bench first stores a word whose top bits differ from one another. It then pulses `ser_clk` several times with the strobe high and watches `ser_dout`, which must not move. Finally it fires a load with no shifting, which re-commits the untouched register; the stored channels must come out identical. The chaining check reads a stored word back on `ser_dout` one bit at a time while a second word shifts in.

// File: rtl/octal_dac_pkg.sv
package octal_dac_pkg;
  localparam int DEF_NCH      = 8;
  localparam int DEF_CODE_W   = 10;
  localparam int DEF_ADDR_W   = 4;
  localparam int DEF_WORD_W   = 16;
  localparam int DEF_SYNC_LEN = 2;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_din,
  input  logic ser_load_n,
  output logic shift_fire,
  output logic din_s,
  output logic commit
);
  // bit 2: load strobe, bit 1: serial clock, bit 0: data
  localparam logic [2:0] IDLE = 3'b100;

  logic [2:0] stg [SYNC_LEN];
  logic [2:0] prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= IDLE;
    else     stg[0] <= {ser_load_n, ser_clk, ser_din};
  end

  for (genvar s = 1; s < SYNC_LEN; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= IDLE;
      else     stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= stg[SYNC_LEN-1];
  end

  assign din_s      = stg[SYNC_LEN-1][0];
  assign shift_fire = stg[SYNC_LEN-1][1] & ~prev[1] & ~stg[SYNC_LEN-1][2];
  assign commit     = stg[SYNC_LEN-1][2] & ~prev[2];
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              dout
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        word <= '0;
    else if (rst)      word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], din};
  end

  assign dout = word[WORD_W-1];
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode #(
  parameter int ADDR_W = 4,
  parameter int NCH    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    wr_mask,
  output logic              go_sleep
);
  localparam logic [ADDR_W-1:0] ALL_ADDR   = '1;
  localparam logic [ADDR_W-1:0] SLEEP_ADDR = ALL_ADDR - 1'b1;

  always_comb begin
    wr_mask  = '0;
    go_sleep = (addr == SLEEP_ADDR);
    if (addr == ALL_ADDR) begin
      wr_mask = '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(i + 1)) wr_mask[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/channel_bank.sv
module channel_bank #(
  parameter int NCH    = 8,
  parameter int CODE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_n,
  input  logic                  commit,
  input  logic [NCH-1:0]        wr_mask,
  input  logic [CODE_W-1:0]     code_in,
  output logic [NCH*CODE_W-1:0] codes
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                    codes[g*CODE_W +: CODE_W] <= '0;
      else if (rst)                  codes[g*CODE_W +: CODE_W] <= '0;
      else if (commit && wr_mask[g]) codes[g*CODE_W +: CODE_W] <= code_in;
    end
  end
endmodule

// File: rtl/octal_dac_ctrl.sv
module octal_dac_ctrl
  import octal_dac_pkg::*;
#(
  parameter int NCH      = DEF_NCH,
  parameter int CODE_W   = DEF_CODE_W,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int WORD_W   = DEF_WORD_W,
  parameter int SYNC_LEN = DEF_SYNC_LEN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_n,
  input  logic                  ser_clk,
  input  logic                  ser_din,
  input  logic                  ser_load_n,
  output logic                  ser_dout,
  output logic [NCH*CODE_W-1:0] ch_code,
  output logic [NCH-1:0]        ch_hiz,
  output logic                  sleep
);
  localparam int CODE_LSB = WORD_W - ADDR_W - CODE_W;

  logic              shift_fire, din_s, commit;
  logic [WORD_W-1:0] sreg;
  logic [NCH-1:0]    wr_mask;
  logic              go_sleep;
  logic              unused_pad;

  assign unused_pad = ^sreg[CODE_LSB-1:0];

  serial_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load_n(ser_load_n), .shift_fire(shift_fire), .din_s(din_s),
    .commit(commit)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .clr_n(clr_n), .shift_en(shift_fire),
    .din(din_s), .word(sreg), .dout(ser_dout)
  );

  cmd_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .addr(sreg[WORD_W-1 -: ADDR_W]), .wr_mask(wr_mask), .go_sleep(go_sleep)
  );

  channel_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst(rst), .clr_n(clr_n), .commit(commit),
    .wr_mask(wr_mask), .code_in(sreg[CODE_LSB +: CODE_W]), .codes(ch_code)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sleep  <= 1'b0;
      ch_hiz <= '0;
    end else if (rst) begin
      sleep  <= 1'b0;
      ch_hiz <= '0;
    end else if (commit) begin
      sleep  <= go_sleep;
      ch_hiz <= {NCH{go_sleep}};
    end
  end
endmodule

// File: rtl/octal_dac_ctrl_chk.sv
module octal_dac_ctrl_chk #(
  parameter int NCH    = 8,
  parameter int CODE_W = 10,
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clr_n,
  input logic                  shift_fire,
  input logic                  commit,
  input logic [WORD_W-1:0]     sreg,
  input logic [NCH*CODE_W-1:0] ch_code,
  input logic [NCH-1:0]        ch_hiz,
  input logic                  sleep
);
  localparam int CODE_LSB = WORD_W - ADDR_W - CODE_W;
  logic [ADDR_W-1:0] addr;
  logic              nochg;
  assign addr  = sreg[WORD_W-1 -: ADDR_W];
  assign nochg = (addr == '0) || (int'(addr) > NCH && addr < ADDR_W'((1 << ADDR_W) - 2));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !shift_fire |=> $stable(sreg));
  assert_shift_chain_R8: assert property (@(posedge clk) disable iff (rst || !clr_n)
    shift_fire |=> sreg[WORD_W-1:1] == $past(sreg[WORD_W-2:0]));
  assert_no_change_R5: assert property (@(posedge clk) disable iff (rst || !clr_n)
    commit && nochg |=> $stable(ch_code));
  assert_sleep_keep_R6: assert property (@(posedge clk) disable iff (rst || !clr_n)
    commit && addr == ADDR_W'((1 << ADDR_W) - 2) |=> sleep && $stable(ch_code));
  assert_hiz_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ch_hiz == {NCH{sleep}});
  assert_wake_R7: assert property (@(posedge clk) disable iff (rst || !clr_n)
    commit && addr != ADDR_W'((1 << ADDR_W) - 2) |=> !sleep);
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> ch_code == '0 && !sleep && sreg == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_bc
    assert_broadcast_R4: assert property (@(posedge clk) disable iff (rst || !clr_n)
      commit && addr == '1 |=> ch_code[g*CODE_W +: CODE_W] == $past(sreg[CODE_LSB +: CODE_W]));
  end
endmodule

bind octal_dac_ctrl octal_dac_ctrl_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .shift_fire(shift_fire),
  .commit(commit), .sreg(sreg), .ch_code(ch_code), .ch_hiz(ch_hiz),
  .sleep(sleep)
);

// File: tb/octal_dac_ctrl_test.sv
module octal_dac_ctrl_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic        clk = 1'b0, rst = 1'b1, clr_n = 1'b1;
  logic        ser_clk = 1'b0, ser_din = 1'b0, ser_load_n = 1'b1;
  logic        ser_dout, sleep;
  logic [79:0] ch_code;
  logic [7:0]  ch_hiz;

  int n_chk = 0, n_bad = 0;

  typedef struct {
    logic [79:0] codes;
    logic        slp;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  event chk_ev;

  logic [9:0] mdl [8];
  logic       msleep;

  octal_dac_ctrl uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_load_n(ser_load_n), .ser_dout(ser_dout),
    .ch_code(ch_code), .ch_hiz(ch_hiz), .sleep(sleep)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] pack_model();
    logic [79:0] v;
    for (int i = 0; i < 8; i++) v[i*10 +: 10] = mdl[i];
    return v;
  endfunction

  // monitor: pops expected states and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, ch_code, e.codes);
        check(e.req, {79'd0, sleep}, {79'd0, e.slp});
        check(e.req, {72'd0, ch_hiz}, {72'd0, {8{e.slp}}});
      end
    end
  end

  task automatic shift_bit(input logic b);
    ser_din = b;
    wait_clk(HALF);
    ser_clk = 1'b1;
    wait_clk(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic model_load(input logic [15:0] w);
    logic [3:0] a;
    a = w[15:12];
    if (a == 4'hE) msleep = 1'b1;
    else begin
      msleep = 1'b0;
      if (a == 4'hF) for (int i = 0; i < 8; i++) mdl[i] = w[11:2];
      else if (a >= 4'd1 && a <= 4'd8) mdl[a-1] = w[11:2];
    end
  endtask

  task automatic finish_load(input logic [15:0] w, input string req);
    wait_clk(HALF);
    ser_load_n = 1'b1;
    model_load(w);
    exp_q.push_back('{pack_model(), msleep, req});
    wait_clk(8);
    -> chk_ev;
    wait_clk(1);
  endtask

  task automatic send(input logic [15:0] w, input string req);
    ser_load_n = 1'b0;
    wait_clk(HALF);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    finish_load(w, req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    msleep = 1'b0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    // R10: state after power-on reset
    check("R10", ch_code, 80'd0);
    check("R10", {79'd0, sleep}, 80'd0);
    check("R10", {72'd0, ch_hiz}, 80'd0);
    check("R10", {79'd0, ser_dout}, 80'd0);

    // R3: each channel addressed on its own
    for (int c = 0; c < 8; c++)
      send({4'(c + 1), 10'(10'h041 * (c + 1)), 2'b00}, "R3");
    // R4: broadcast
    send({4'hF, 10'h2AB, 2'b00}, "R4");
    send({4'h3, 10'h155, 2'b11}, "R3");
    send({4'h8, 10'h3FF, 2'b01}, "R3");
    // R5: no-change addresses
    send({4'h0, 10'h001, 2'b00}, "R5");
    send({4'h9, 10'h3C3, 2'b00}, "R5");
    send({4'hD, 10'h0F0, 2'b10}, "R5");
    // R6: sleep, code ignored
    send({4'hE, 10'h123, 2'b00}, "R6");
    // R7: wake through a no-change address
    send({4'hB, 10'h200, 2'b00}, "R7");
    // R7: wake through a single-channel write
    send({4'hE, 10'h000, 2'b00}, "R6");
    send({4'h2, 10'h0F0, 2'b00}, "R7");

    // R2: serial-clock edges with the strobe high must not shift
    send({4'h4, 10'h0AA, 2'b00}, "R2");
    for (int k = 0; k < 5; k++) begin
      shift_bit(1'b1);
      wait_clk(2);
      check("R2", {79'd0, ser_dout}, 80'd0);
    end
    ser_load_n = 1'b0;
    finish_load({4'h4, 10'h0AA, 2'b00}, "R2");

    // R1: extra leading bits are dropped, the last 16 are decoded
    ser_load_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < 5; k++) shift_bit(1'b1);
    for (int i = 15; i >= 0; i--) shift_bit(16'h6C8B >> i);
    finish_load(16'h6C8B, "R1");

    // R8: the stored word leaves MSB first while the next one shifts in
    begin
      logic [15:0] prevw, nextw;
      prevw = 16'h6C8B;
      nextw = {4'h5, 10'h2D2, 2'b00};
      ser_load_n = 1'b0;
      wait_clk(HALF);
      for (int i = 15; i >= 0; i--) begin
        check("R8", {79'd0, ser_dout}, {79'd0, prevw[i]});
        shift_bit(nextw[i]);
        wait_clk(2);
      end
      finish_load(nextw, "R8");
    end

    // R9: asynchronous clear while asleep
    send({4'hE, 10'h3AA, 2'b00}, "R6");
    @(posedge clk);
    #2;
    clr_n = 1'b0;
    #1;
    check("R9", ch_code, 80'd0);
    check("R9", {79'd0, sleep}, 80'd0);
    wait_clk(2);
    check("R9", {79'd0, ser_dout}, 80'd0);
    clr_n = 1'b1;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    msleep = 1'b0;
    wait_clk(2);
    // an empty load after clear decodes the zeroed register (no change)
    ser_load_n = 1'b0;
    finish_load(16'h0000, "R9");

    // R10: synchronous reset in the middle of operation
    send({4'hF, 10'h155, 2'b00}, "R4");
    send({4'hE, 10'h000, 2'b00}, "R6");
    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(1);
    check("R10", ch_code, 80'd0);
    check("R10", {79'd0, sleep}, 80'd0);
    check("R10", {72'd0, ch_hiz}, 80'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule